// File: doc/BRIEF.md
# Single-Cycle Word-Addressed Integer Core

This block is a small processor core that completes one instruction per clock cycle. It runs a subset of a 32-bit load/store integer instruction set:
- register-register ALU operations;
- register-immediate ALU operations, including shifts by an immediate amount;
- a word load and a word store;
- branch-if-equal.

The core holds a program counter, a read-only program image, a register file, an immediate generator, an ALU, two decoders and a data array. The program image is a parameter of the core and is fixed at elaboration.

All addresses are word indices. The program counter steps by one per instruction, and load/store offsets count words. Branch offsets are encoded in bytes as usual, and the core divides them by four before adding them to the PC.

The only inputs are clock and a synchronous active-high reset. For observation the core exposes:
- the current PC;
- the instruction at that PC;
- a registered probe of the register-file write that the last clock edge committed.

Top module: `scalar_core`

## Requirements
- R1: While reset is high, a clock edge sets the PC to 0 and clears the write probe valid bit. After reset is released, `dbg_instr` is word 0 of the program image.
- R2: Each clock edge out of reset advances the PC by exactly 1 unless a branch is taken.
- R3: Source 1 is read from instruction bits 19:15, source 2 from bits 24:20, and the destination is bits 11:7. Register 0 always reads as zero, even after a write to it is attempted.
- R4: Opcode 51 (register-register) picks the operation from funct3. The mapping is: 0 add (sub when bit 30 is 1), 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 logical shift right (arithmetic when bit 30 is 1), 6 or, 7 and. The less-than operations return 1 or 0.
- R5: Opcode 19 (register-immediate) uses bits 31:20 as the operand, sign-extended from bit 31. For funct3 0, bit 30 does not select subtract.
- R6: With opcode 19 and funct3 1 or 5, bits 24:20 are the shift amount and bit 30 selects arithmetic over logical right shift.
- R7: Every shift uses only the low 5 bits of its amount.
- R8: Opcode 35 (store) writes source 2 to data word (source 1 + sign-extended {bits 31:25, bits 11:7}) modulo 32. It does not write the register file.
- R9: Opcode 3 (load) writes data word (source 1 + sign-extended bits 31:20) modulo 32 into the destination register.
- R10: Opcode 99 with funct3 0 is branch-if-equal, and it never writes a register. The byte offset is {bit 31, bit 7, bits 30:25, bits 11:8, 0}, sign-extended. When the two sources are equal, the next PC is the PC plus that offset shifted arithmetically right by 2. Otherwise the next PC is the PC plus 1.
- R11: Any other opcode writes neither the register file nor data memory, and the PC advances by 1.
- R12: One cycle after each edge, the write probe reports that edge's register write: valid, destination index and data. The probe valid bit is low after an edge that performed no register write.
- R13: With the default program image (00600293, 00700313, 006283b3), registers 5, 6 and 7 receive 6, 7 and 13 on the first three edges after reset.
- R14: `dbg_instr` always equals the program image word selected by the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | XLEN | Current program counter (word index) |
| dbg_instr | output | XLEN | Instruction word at the current PC |
| dbg_wr_en | output | 1 | Register write performed on the last edge |
| dbg_wr_idx | output | log2(NREGS) | Destination index of that write |
| dbg_wr_data | output | XLEN | Data written on that edge |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- An immediate add of -8 has bit 30 set. A decoder that honours the subtract bit for immediates would return +8 instead.
- Arithmetic and logical right shifts of a negative value, a left shift by 31, and a register shift by 33 expose sign fill, the shift-left path and amount truncation. A core that does not mask the amount to 5 bits would produce zero instead of 14.
- A store with a negative offset followed by a load from the same word exposes a bad store immediate as a wrong load value.
- An add into register 0 followed by a read of register 0 catches a core that keeps the value.
- Untaken, forward-taken and backward-taken branches, plus an illegal opcode whose destination field names a live register, expose wrong targets, missing sign extension of the offset, and spurious writes.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam logic [6:0] OPC_REG    = 7'd51;
  localparam logic [6:0] OPC_IMM    = 7'd19;
  localparam logic [6:0] OPC_LOAD   = 7'd3;
  localparam logic [6:0] OPC_STORE  = 7'd35;
  localparam logic [6:0] OPC_BRANCH = 7'd99;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_SLL  = 4'd2,
    ALU_SLT  = 4'd3,
    ALU_SLTU = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_SRL  = 4'd6,
    ALU_SRA  = 4'd7,
    ALU_OR   = 4'd8,
    ALU_AND  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_I  = 2'd0,
    IMM_SH = 2'd1,
    IMM_S  = 2'd2,
    IMM_B  = 2'd3
  } imm_kind_e;

  typedef struct packed {
    logic      reg_we;
    logic      mem_we;
    logic      alu_imm;
    logic      wb_mem;
    logic      branch;
    imm_kind_e imm_kind;
    alu_op_e   alu_op;
  } ctrl_t;

endpackage

// File: rtl/scp_decoder.sv
module scp_decoder
  import scp_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic       alt_bit,
  output ctrl_t      ctrl
);

  // Operation decoder: funct3 selects the operation; alt_bit only picks sub
  // when the caller permits it (register-register form).
  function automatic alu_op_e pick_op(input logic [2:0] f3, input logic alt,
                                      input logic sub_ok);
    case (f3)
      3'd0:    pick_op = (sub_ok && alt) ? ALU_SUB : ALU_ADD;
      3'd1:    pick_op = ALU_SLL;
      3'd2:    pick_op = ALU_SLT;
      3'd3:    pick_op = ALU_SLTU;
      3'd4:    pick_op = ALU_XOR;
      3'd5:    pick_op = alt ? ALU_SRA : ALU_SRL;
      3'd6:    pick_op = ALU_OR;
      default: pick_op = ALU_AND;
    endcase
  endfunction

  // Main decoder
  always_comb begin
    ctrl = '0;
    case (opcode)
      OPC_REG: begin
        ctrl.reg_we = 1'b1;
        ctrl.alu_op = pick_op(funct3, alt_bit, 1'b1);
      end
      OPC_IMM: begin
        ctrl.reg_we   = 1'b1;
        ctrl.alu_imm  = 1'b1;
        ctrl.imm_kind = (funct3 == 3'd1 || funct3 == 3'd5) ? IMM_SH : IMM_I;
        ctrl.alu_op   = pick_op(funct3, alt_bit, 1'b0);
      end
      OPC_LOAD: begin
        ctrl.reg_we   = 1'b1;
        ctrl.alu_imm  = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.imm_kind = IMM_I;
        ctrl.alu_op   = ALU_ADD;
      end
      OPC_STORE: begin
        ctrl.mem_we   = 1'b1;
        ctrl.alu_imm  = 1'b1;
        ctrl.imm_kind = IMM_S;
        ctrl.alu_op   = ALU_ADD;
      end
      OPC_BRANCH: begin
        if (funct3 == 3'd0) begin
          ctrl.branch   = 1'b1;
          ctrl.imm_kind = IMM_B;
        end
      end
      default: ctrl = '0;
    endcase
  end

  always_comb begin
    if (opcode == OPC_STORE)
      p_store_no_regwr_r8: assert (ctrl.mem_we && !ctrl.reg_we);
    if (opcode == OPC_BRANCH)
      p_branch_no_write_r10: assert (!ctrl.reg_we && !ctrl.mem_we);
    if (!(opcode inside {OPC_REG, OPC_IMM, OPC_LOAD, OPC_STORE, OPC_BRANCH}))
      p_unknown_quiet_r11: assert (!ctrl.reg_we && !ctrl.mem_we && !ctrl.branch);
  end

endmodule

// File: rtl/scp_imm_gen.sv
module scp_imm_gen
  import scp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:7]     instr_hi,
  input  imm_kind_e       kind,
  output logic [XLEN-1:0] imm
);

  logic [31:0] field_i, field_sh, field_s, field_b;

  assign field_i  = {{20{instr_hi[31]}}, instr_hi[31:20]};
  assign field_sh = {27'd0, instr_hi[24:20]};
  assign field_s  = {{20{instr_hi[31]}}, instr_hi[31:25], instr_hi[11:7]};
  assign field_b  = {{19{instr_hi[31]}}, instr_hi[31], instr_hi[7],
                     instr_hi[30:25], instr_hi[11:8], 1'b0};

  always_comb begin
    case (kind)
      IMM_I:   imm = XLEN'(signed'(field_i));
      IMM_SH:  imm = XLEN'(field_sh);
      IMM_S:   imm = XLEN'(signed'(field_s));
      default: imm = XLEN'(signed'(field_b));
    endcase
  end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] res
);

  localparam int SH_W = $clog2(XLEN);

  logic [SH_W-1:0] shamt;
  assign shamt = b[SH_W-1:0];

  always_comb begin
    case (op)
      ALU_ADD:  res = a + b;
      ALU_SUB:  res = a - b;
      ALU_SLL:  res = a << shamt;
      ALU_SLT:  res = XLEN'($signed(a) < $signed(b));
      ALU_SLTU: res = XLEN'(a < b);
      ALU_XOR:  res = a ^ b;
      ALU_SRL:  res = a >> shamt;
      ALU_SRA:  res = $unsigned($signed(a) >>> shamt);
      ALU_OR:   res = a | b;
      ALU_AND:  res = a & b;
      default:  res = '0;
    endcase
  end

  always_comb begin
    if (op == ALU_SLT || op == ALU_SLTU)
      p_compare_is_flag_r4: assert (res[XLEN-1:1] == '0);
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);

  logic [XLEN-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];

endmodule

// File: rtl/scalar_core.sv
module scalar_core
  import scp_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREGS      = 32,
  parameter int IMEM_WORDS = 32,
  parameter int DMEM_WORDS = 32,
  parameter logic [IMEM_WORDS*XLEN-1:0] INIT_IMAGE =
    {{((IMEM_WORDS-3)*XLEN){1'b0}}, 32'h006283b3, 32'h00700313, 32'h00600293},
  localparam int RAW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] dbg_pc,
  output logic [XLEN-1:0] dbg_instr,
  output logic            dbg_wr_en,
  output logic [RAW-1:0]  dbg_wr_idx,
  output logic [XLEN-1:0] dbg_wr_data
);

  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  // Program counter and instruction image
  logic [XLEN-1:0] pc_q, pc_next;
  logic [XLEN-1:0] rom [IMEM_WORDS];
  logic [31:0]     instr;

  for (genvar g = 0; g < IMEM_WORDS; g++) begin : g_rom
    assign rom[g] = INIT_IMAGE[g*XLEN +: XLEN];
  end

  assign instr = rom[pc_q[IAW-1:0]][31:0];

  // Decode
  ctrl_t ctrl;
  scp_decoder u_dec (
    .opcode  (instr[6:0]),
    .funct3  (instr[14:12]),
    .alt_bit (instr[30]),
    .ctrl    (ctrl)
  );

  logic [XLEN-1:0] imm;
  scp_imm_gen #(.XLEN(XLEN)) u_imm (
    .instr_hi (instr[31:7]),
    .kind     (ctrl.imm_kind),
    .imm      (imm)
  );

  // Register file
  logic [XLEN-1:0] rs1_val, rs2_val, wb_val;
  scp_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk (clk),
    .we  (ctrl.reg_we),
    .wa  (instr[11:7]),
    .wd  (wb_val),
    .ra1 (instr[19:15]),
    .ra2 (instr[24:20]),
    .rd1 (rs1_val),
    .rd2 (rs2_val)
  );

  // Execute
  logic [XLEN-1:0] alu_b, alu_res;
  assign alu_b = ctrl.alu_imm ? imm : rs2_val;

  scp_alu #(.XLEN(XLEN)) u_alu (
    .a   (rs1_val),
    .b   (alu_b),
    .op  (ctrl.alu_op),
    .res (alu_res)
  );

  // Data array: synchronous write, asynchronous read
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [DAW-1:0]  daddr;
  logic [XLEN-1:0] dread;

  assign daddr = alu_res[DAW-1:0];
  assign dread = dmem[daddr];

  always_ff @(posedge clk) begin
    if (ctrl.mem_we && !rst) dmem[daddr] <= rs2_val;
  end

  assign wb_val = ctrl.wb_mem ? dread : alu_res;

  // Next PC: branch offsets are bytes, the PC counts words
  logic take;
  assign take    = ctrl.branch && (rs1_val == rs2_val);
  assign pc_next = take ? pc_q + $unsigned($signed(imm) >>> 2) : pc_q + XLEN'(1);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // Registered write probe
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_wr_en   <= 1'b0;
      dbg_wr_idx  <= '0;
      dbg_wr_data <= '0;
    end else begin
      dbg_wr_en   <= ctrl.reg_we;
      dbg_wr_idx  <= instr[11:7];
      dbg_wr_data <= wb_val;
    end
  end

  assign dbg_pc    = pc_q;
  assign dbg_instr = XLEN'(instr);

  // Checks
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) p_reset_clear_r1: assert (pc_q == '0 && !dbg_wr_en);
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc_q == $past(pc_q) + XLEN'(1));

  p_branch_target_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> pc_q == $past(pc_q + $unsigned($signed(imm) >>> 2)));

  p_probe_follows_r12: assert property (@(posedge clk) disable iff (rst)
    ctrl.reg_we |=> (dbg_wr_en && dbg_wr_data == $past(wb_val)));

  p_probe_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !ctrl.reg_we |=> !dbg_wr_en);

endmodule

// File: tb/test_scalar_core.sv
module test_scalar_core;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 26;

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'd51};
  endfunction

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
      input logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'd2, imm[4:0], 7'd35};
  endfunction

  function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] rs2,
      input logic [4:0] rs1);
    return {imm[12], imm[10:5], rs2, rs1, 3'd0, imm[4:1], imm[11], 7'd99};
  endfunction

  function automatic logic [1023:0] build_prog();
    logic [31:0] w [32];
    logic [1023:0] img;
    for (int i = 0; i < 32; i++) w[i] = 32'd0;
    w[0]  = enc_i(12'd6, 5'd0, 3'd0, 5'd5, 7'd19);
    w[1]  = enc_i(12'd7, 5'd0, 3'd0, 5'd6, 7'd19);
    w[2]  = enc_r(7'h00, 5'd6, 5'd5, 3'd0, 5'd7);
    w[3]  = enc_r(7'h20, 5'd6, 5'd5, 3'd0, 5'd8);
    w[4]  = enc_i(12'hFF8, 5'd0, 3'd0, 5'd9, 7'd19);
    w[5]  = enc_i({7'h20, 5'd2}, 5'd9, 3'd5, 5'd10, 7'd19);
    w[6]  = enc_i({7'h00, 5'd28}, 5'd9, 3'd5, 5'd11, 7'd19);
    w[7]  = enc_i({7'h00, 5'd31}, 5'd6, 3'd1, 5'd12, 7'd19);
    w[8]  = enc_r(7'h00, 5'd5, 5'd9, 3'd2, 5'd13);
    w[9]  = enc_r(7'h00, 5'd5, 5'd9, 3'd3, 5'd14);
    w[10] = enc_r(7'h00, 5'd6, 5'd5, 3'd4, 5'd15);
    w[11] = enc_r(7'h00, 5'd6, 5'd5, 3'd6, 5'd16);
    w[12] = enc_r(7'h00, 5'd6, 5'd5, 3'd7, 5'd17);
    w[13] = enc_s(12'hFFF, 5'd7, 5'd5);
    w[14] = enc_i(12'd5, 5'd0, 3'd2, 5'd18, 7'd3);
    w[15] = enc_i(12'd5, 5'd5, 3'd0, 5'd0, 7'd19);
    w[16] = enc_r(7'h00, 5'd6, 5'd0, 3'd0, 5'd19);
    w[17] = enc_b(13'd8, 5'd6, 5'd5);
    w[18] = enc_b(13'd12, 5'd5, 5'd5);
    w[19] = enc_i(12'd1, 5'd0, 3'd0, 5'd20, 7'd19);
    w[20] = enc_i(12'd2, 5'd0, 3'd0, 5'd20, 7'd19);
    w[21] = 32'h00500AFF;
    w[22] = enc_i(12'd33, 5'd0, 3'd0, 5'd20, 7'd19);
    w[23] = enc_r(7'h00, 5'd20, 5'd6, 3'd1, 5'd22);
    w[24] = enc_b(13'd8, 5'd0, 5'd0);
    w[25] = enc_i(12'd9, 5'd0, 3'd0, 5'd25, 7'd19);
    w[26] = enc_b(13'h1FF8, 5'd0, 5'd0);
    img = '0;
    for (int i = 0; i < 32; i++) img[i*32 +: 32] = w[i];
    return img;
  endfunction

  localparam logic [1023:0] PROG = build_prog();

  // {req[3:0], pc after edge[7:0], wr_en, wr_idx[4:0], wr_data[31:0]}
  localparam logic [49:0] VEC [NV] = '{
    {4'd5,  8'd1,  1'b1, 5'd5,  32'h00000006},  // R5 addi
    {4'd5,  8'd2,  1'b1, 5'd6,  32'h00000007},  // R5
    {4'd4,  8'd3,  1'b1, 5'd7,  32'h0000000D},  // R4 add
    {4'd4,  8'd4,  1'b1, 5'd8,  32'hFFFFFFFF},  // R4 sub
    {4'd5,  8'd5,  1'b1, 5'd9,  32'hFFFFFFF8},  // R5 negative imm, bit 30 set
    {4'd6,  8'd6,  1'b1, 5'd10, 32'hFFFFFFFE},  // R6 srai
    {4'd6,  8'd7,  1'b1, 5'd11, 32'h0000000F},  // R6 srli
    {4'd6,  8'd8,  1'b1, 5'd12, 32'h80000000},  // R6 slli 31
    {4'd4,  8'd9,  1'b1, 5'd13, 32'h00000001},  // R4 slt signed
    {4'd4,  8'd10, 1'b1, 5'd14, 32'h00000000},  // R4 sltu
    {4'd4,  8'd11, 1'b1, 5'd15, 32'h00000001},  // R4 xor
    {4'd4,  8'd12, 1'b1, 5'd16, 32'h00000007},  // R4 or
    {4'd4,  8'd13, 1'b1, 5'd17, 32'h00000006},  // R4 and
    {4'd8,  8'd14, 1'b0, 5'd0,  32'h00000000},  // R8 store, no reg write
    {4'd9,  8'd15, 1'b1, 5'd18, 32'h0000000D},  // R9 load back
    {4'd3,  8'd16, 1'b1, 5'd0,  32'h0000000B},  // R3 write to x0 attempted
    {4'd3,  8'd17, 1'b1, 5'd19, 32'h00000007},  // R3 x0 reads zero
    {4'd10, 8'd18, 1'b0, 5'd0,  32'h00000000},  // R10 not taken
    {4'd10, 8'd21, 1'b0, 5'd0,  32'h00000000},  // R10 taken forward
    {4'd11, 8'd22, 1'b0, 5'd0,  32'h00000000},  // R11 unknown opcode
    {4'd5,  8'd23, 1'b1, 5'd20, 32'h00000021},  // R5
    {4'd7,  8'd24, 1'b1, 5'd22, 32'h0000000E},  // R7 shift by 33
    {4'd10, 8'd26, 1'b0, 5'd0,  32'h00000000},  // R10 forward
    {4'd10, 8'd24, 1'b0, 5'd0,  32'h00000000},  // R10 backward
    {4'd10, 8'd26, 1'b0, 5'd0,  32'h00000000},  // R10
    {4'd10, 8'd24, 1'b0, 5'd0,  32'h00000000}   // R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc, instr, wdata, d_pc, d_instr, d_wdata;
  logic        wen, d_wen;
  logic [4:0]  widx, d_widx;
  int          checks = 0;
  int          failures = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scalar_core #(.INIT_IMAGE(PROG)) i_scalar_core (
    .clk (clk), .rst (rst), .dbg_pc (pc), .dbg_instr (instr),
    .dbg_wr_en (wen), .dbg_wr_idx (widx), .dbg_wr_data (wdata)
  );

  scalar_core i_scalar_core_default (
    .clk (clk), .rst (rst), .dbg_pc (d_pc), .dbg_instr (d_instr),
    .dbg_wr_en (d_wen), .dbg_wr_idx (d_widx), .dbg_wr_data (d_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", pc, 32'd0);
    chk("R1 probe in reset", {31'd0, wen}, 32'd0);
    chk("R14 instr at reset", instr, PROG[31:0]);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R%0d pc step %0d", v[49:46], i), pc, {24'd0, v[45:38]});
      chk($sformatf("R14 instr step %0d", i), instr, PROG[v[45:38]*32 +: 32]);
      chk($sformatf("R12/R%0d probe valid step %0d", v[49:46], i), {31'd0, wen}, {31'd0, v[37]});
      if (v[37]) begin
        chk($sformatf("R3/R12 probe idx step %0d", i), {27'd0, widx}, {27'd0, v[36:32]});
        chk($sformatf("R%0d probe data step %0d", v[49:46], i), wdata, v[31:0]);
      end
      if (i < 3) begin
        chk("R13 default pc", d_pc, {24'd0, v[45:38]});
        chk("R13 default write", {26'd0, d_wen, d_widx}, {26'd0, 1'b1, v[36:32]});
        chk("R13 default data", d_wdata, v[31:0]);
      end
    end
    // Directed: reset in the middle of a run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc after mid-run reset", pc, 32'd0);
    chk("R1 probe after mid-run reset", {31'd0, wen}, 32'd0);
    chk("R14 instr after mid-run reset", instr, PROG[31:0]);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 pc after restart", pc, 32'd1);
    chk("R12 probe after restart", {26'd0, wen, widx}, {26'd0, 1'b1, 5'd5});
    chk("R12 data after restart", wdata, 32'd6);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule